// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block owns the SDRAM command pins from reset until the memory is usable, and afterwards borrows them from the system arbiter whenever refresh work is owed. After reset it holds the bus idle for a power-up wait, closes every bank, runs a fixed number of auto-refresh cycles, then writes the standard mode word and the extended (low-power) mode word. Both words are parameters. The standard word is assembled by a package function from burst length, burst type, CAS latency and the single-write flag. The extended word is assembled from the temperature-compensation and partial-array settings.

Once the extended word has settled, `ready` rises and stays high. A free-running interval timer then adds one owed refresh every `REF_INTERVAL` cycles. The default interval of 2080 cycles is 64 ms divided by 4096 rows at 133 MHz. While any refresh is owed, the block raises `bus_req`. On a cycle where the arbiter answers with `bus_grant`, the block closes all banks and issues one auto-refresh. It repeats this until nothing is owed. The owed count saturates at `MAX_OWED`, so a long stall by the arbiter can defer at most that many refreshes. Read and write traffic is not handled here.

Top module: `sdr_init_refresh`

## Requirements
- R1: While `rst` is high, and after release until the first command, the command pins `{cs_n,ras_n,cas_n,we_n}` read 4'b0111 (idle), and `ready` and `bus_req` are low.
- R2: Exactly `INIT_WAIT` idle cycles, counted from the first cycle after reset release, pass before the first command.
- R3: The start-up commands come in this order. First a close-all (4'b0010 with `addr` bit 10 high). Then `INIT_REFS` auto-refreshes (4'b0001). Then a standard mode load (4'b0000, `ba`=0, `addr`=`MODE_VAL`). Then an extended mode load (4'b0000, `ba`=2'b10, `addr`=`EXT_MODE_VAL`). In the standard word, bits 2:0 are the burst length code, bit 3 the burst type, bits 6:4 the CAS latency and bit 9 single-write. In the extended word, bits 2:0 are the partial-array code and bits 4:3 the temperature code.
- R4: During start-up, exactly `T_RP` idle cycles follow a close-all, `T_RC` follow an auto-refresh, and `T_MRD` follow a mode load. After start-up, at least that many idle cycles follow each command.
- R5: `ready` rises `T_MRD`+1 cycles after the extended mode load and never falls until reset.
- R6: One refresh becomes owed every `REF_INTERVAL` cycles, counted from the cycle `ready` rises. `bus_req` first rises exactly `REF_INTERVAL` cycles after `ready`, and it is high whenever a refresh is owed.
- R7: After `ready`, no command is issued in a cycle with `bus_grant` low. When `bus_req` and `bus_grant` are both seen high from idle, a close-all follows in the next cycle and an auto-refresh `T_RP`+1 cycles after that.
- R8: After `ready`, every auto-refresh is immediately preceded, as the last command, by a close-all with `addr` bit 10 high.
- R9: The owed count saturates at `MAX_OWED`. A grant withheld for more than `MAX_OWED` intervals yields exactly `MAX_OWED` refreshes in the following burst.
- R10: Once granted, `bus_req` stays high across back-to-back refreshes until the owed count is zero. The number of refreshes in a burst equals the count owed, including any that come due during the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_grant | input | 1 | Arbiter hands the command bus to this block |
| bus_req | output | 1 | Refresh owed or in progress; asks for the bus |
| ready | output | 1 | Start-up sequence finished |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address pins; carries bit 10 for close-all and the mode words |
| ba | output | BA_W | Bank select; 2'b10 selects the extended mode word |

## Verification
The hardest state to reach is a saturated owed count. It appears only after the arbiter has refused the bus for more than eight full refresh intervals. A second hard case is a refresh coming due in the same cycle that one is served. The bench withholds `bus_grant` for over ten intervals and then counts the burst. It also grants after random delays, so some grants land near interval boundaries. A bench-side model of the owed count, updated from the observed refresh commands and the interval schedule, must reach zero at the end of every burst.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    // Command pins, all active low.
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_IDLE  = 4'b0111;
    localparam sdr_cmd_t CMD_CLOSE = 4'b0010;
    localparam sdr_cmd_t CMD_RFSH  = 4'b0001;
    localparam sdr_cmd_t CMD_MODE  = 4'b0000;

    typedef enum logic [3:0] {
        ST_PWR,
        ST_ICLOSE, ST_ICLOSE_W,
        ST_IRFSH,  ST_IRFSH_W,
        ST_MODE,   ST_MODE_W,
        ST_XMODE,  ST_XMODE_W,
        ST_IDLE,
        ST_CLOSE,  ST_CLOSE_W,
        ST_RFSH,   ST_RFSH_W
    } seq_state_t;

    // Standard mode word: bits 2:0 burst length code, 3 burst type,
    // 6:4 CAS latency, 9 single-write.
    function automatic logic [11:0] mode_word(input logic [2:0] bl_code,
                                              input logic       interleave,
                                              input logic [2:0] cas_lat,
                                              input logic       single_wr);
        return {2'b00, single_wr, 2'b00, cas_lat, interleave, bl_code};
    endfunction

    // Extended mode word: bits 2:0 partial-array code, 4:3 temperature code.
    function automatic logic [11:0] ext_word(input logic [1:0] temp_code,
                                             input logic [2:0] array_code);
        return {7'b0, temp_code, array_code};
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdr_wait_cnt.sv
module sdr_wait_cnt #(
    parameter int W       = 8,
    parameter int RST_VAL = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= W'(RST_VAL);
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == W'(1));
endmodule

// File: rtl/sdr_ref_owed.sv
module sdr_ref_owed #(
    parameter int INTERVAL = 2080,
    parameter int MAX_OWED = 8,
    parameter int OW       = $clog2(MAX_OWED + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          served,
    output logic [OW-1:0] owed
);
    localparam int TW = $clog2(INTERVAL);

    logic [TW-1:0] tcnt;
    logic          tick;

    assign tick = run && (tcnt == TW'(INTERVAL - 1));

    always_ff @(posedge clk) begin
        if (rst || !run)
            tcnt <= '0;
        else if (tick)
            tcnt <= '0;
        else
            tcnt <= tcnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            owed <= '0;
        else if (tick && !served && owed != OW'(MAX_OWED))
            owed <= owed + 1'b1;
        else if (served && !tick && owed != '0)
            owed <= owed - 1'b1;
    end
endmodule

// File: rtl/sdr_init_refresh.sv
module sdr_init_refresh
    import sdr_seq_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int BA_W         = 2,
    parameter int AP_BIT       = 10,
    parameter int INIT_WAIT    = 26600,
    parameter int T_RP         = 3,
    parameter int T_RC         = 9,
    parameter int T_MRD        = 2,
    parameter int INIT_REFS    = 2,
    parameter int REF_INTERVAL = 2080,
    parameter int MAX_OWED     = 8,
    parameter logic [ADDR_W-1:0] MODE_VAL     = ADDR_W'(mode_word(3'd2, 1'b0, 3'd3, 1'b0)),
    parameter logic [ADDR_W-1:0] EXT_MODE_VAL = ADDR_W'(ext_word(2'd0, 3'd0))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_grant,
    output logic              bus_req,
    output logic              ready,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba
);
    localparam int WAIT_MAX = imax(imax(INIT_WAIT, T_RC), imax(T_RP, T_MRD));
    localparam int WAIT_W   = $clog2(WAIT_MAX + 1);
    localparam int RC_W     = $clog2(INIT_REFS + 1);
    localparam int OW       = $clog2(MAX_OWED + 1);
    localparam logic [BA_W-1:0] XMODE_BANK = BA_W'(1) << (BA_W - 1);

    seq_state_t        state, nxt;
    logic              w_load, w_last;
    logic [WAIT_W-1:0] w_val;
    logic [RC_W-1:0]   init_refs;
    logic [OW-1:0]     owed;
    sdr_cmd_t          cmd;

    sdr_wait_cnt #(.W(WAIT_W), .RST_VAL(INIT_WAIT)) u_wait (
        .clk(clk), .rst(rst), .load(w_load), .load_val(w_val), .last(w_last)
    );

    sdr_ref_owed #(.INTERVAL(REF_INTERVAL), .MAX_OWED(MAX_OWED), .OW(OW)) u_owed (
        .clk(clk), .rst(rst), .run(ready), .served(state == ST_RFSH), .owed(owed)
    );

    always_comb begin
        nxt    = state;
        w_load = 1'b0;
        w_val  = '0;
        unique case (state)
            ST_PWR:      if (w_last) nxt = ST_ICLOSE;
            ST_ICLOSE:   begin w_load = 1'b1; w_val = WAIT_W'(T_RP); nxt = ST_ICLOSE_W; end
            ST_ICLOSE_W: if (w_last) nxt = ST_IRFSH;
            ST_IRFSH:    begin w_load = 1'b1; w_val = WAIT_W'(T_RC); nxt = ST_IRFSH_W; end
            ST_IRFSH_W:  if (w_last) nxt = (init_refs == RC_W'(INIT_REFS)) ? ST_MODE : ST_IRFSH;
            ST_MODE:     begin w_load = 1'b1; w_val = WAIT_W'(T_MRD); nxt = ST_MODE_W; end
            ST_MODE_W:   if (w_last) nxt = ST_XMODE;
            ST_XMODE:    begin w_load = 1'b1; w_val = WAIT_W'(T_MRD); nxt = ST_XMODE_W; end
            ST_XMODE_W:  if (w_last) nxt = ST_IDLE;
            ST_IDLE:     if (owed != '0 && bus_grant) nxt = ST_CLOSE;
            ST_CLOSE:    begin w_load = 1'b1; w_val = WAIT_W'(T_RP); nxt = ST_CLOSE_W; end
            ST_CLOSE_W:  if (w_last) nxt = ST_RFSH;
            ST_RFSH:     begin w_load = 1'b1; w_val = WAIT_W'(T_RC); nxt = ST_RFSH_W; end
            ST_RFSH_W:   if (w_last) nxt = ST_IDLE;
            default:     nxt = ST_PWR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_PWR;
            init_refs <= '0;
            ready     <= 1'b0;
        end else begin
            state <= nxt;
            if (state == ST_IRFSH)
                init_refs <= init_refs + 1'b1;
            if (state == ST_XMODE_W && w_last)
                ready <= 1'b1;
        end
    end

    // Pins decoded straight from the state register.
    always_comb begin
        cmd  = CMD_IDLE;
        addr = '0;
        ba   = '0;
        unique case (state)
            ST_ICLOSE, ST_CLOSE: begin cmd = CMD_CLOSE; addr[AP_BIT] = 1'b1; end
            ST_IRFSH, ST_RFSH:   cmd = CMD_RFSH;
            ST_MODE:             begin cmd = CMD_MODE; addr = MODE_VAL; end
            ST_XMODE:            begin cmd = CMD_MODE; addr = EXT_MODE_VAL; ba = XMODE_BANK; end
            default:             cmd = CMD_IDLE;
        endcase
    end

    assign cs_n  = cmd.cs_n;
    assign ras_n = cmd.ras_n;
    assign cas_n = cmd.cas_n;
    assign we_n  = cmd.we_n;

    always_comb begin
        unique case (state)
            ST_IDLE:                                    bus_req = (owed != '0);
            ST_CLOSE, ST_CLOSE_W, ST_RFSH, ST_RFSH_W:   bus_req = 1'b1;
            default:                                    bus_req = 1'b0;
        endcase
    end
endmodule

// File: rtl/sdr_init_refresh_chk.sv
module sdr_init_refresh_chk
    import sdr_seq_pkg::*;
#(
    parameter int BA_W = 2,
    parameter int T_RP = 3,
    parameter int T_RC = 9
) (
    input logic            clk,
    input logic            rst,
    input logic            cs_n,
    input logic            ras_n,
    input logic            cas_n,
    input logic            we_n,
    input logic            a10,
    input logic [BA_W-1:0] ba,
    input logic            ready,
    input logic            bus_req
);
    localparam int GW = $clog2(imax(T_RP, T_RC) + 2);
    localparam logic [GW-1:0] GMAX = {GW{1'b1}};

    sdr_cmd_t      cmd, last_cmd;
    logic          last_a10;
    logic [GW-1:0] gap;

    assign cmd = {cs_n, ras_n, cas_n, we_n};

    always_ff @(posedge clk) begin
        if (rst) begin
            last_cmd <= CMD_IDLE;
            last_a10 <= 1'b0;
            gap      <= '0;
        end else if (cmd != CMD_IDLE) begin
            last_cmd <= cmd;
            last_a10 <= a10;
            gap      <= '0;
        end else if (gap != GMAX) begin
            gap <= gap + 1'b1;
        end
    end

    assert_ready_hold_R5: assert property (@(posedge clk) disable iff (rst)
        ready |=> ready);

    assert_rfsh_after_close_R8: assert property (@(posedge clk) disable iff (rst)
        (ready && cmd == CMD_RFSH) |-> (last_cmd == CMD_CLOSE && last_a10));

    assert_close_gap_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_IDLE && last_cmd == CMD_CLOSE) |-> (gap >= GW'(T_RP)));

    assert_rfsh_gap_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd != CMD_IDLE && last_cmd == CMD_RFSH) |-> (gap >= GW'(T_RC)));

    assert_owned_bus_R7: assert property (@(posedge clk) disable iff (rst)
        (ready && cmd != CMD_IDLE) |-> bus_req);

    assert_mode_bank_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_MODE) |-> (ba == '0 || ba == (BA_W'(1) << (BA_W - 1))));

    assert_req_after_ready_R6: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> ready);
endmodule

bind sdr_init_refresh sdr_init_refresh_chk #(.BA_W(BA_W), .T_RP(T_RP), .T_RC(T_RC)) u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .a10(addr[AP_BIT]), .ba(ba), .ready(ready), .bus_req(bus_req)
);

// File: tb/tb_sdr_init_refresh.sv
module tb_sdr_init_refresh;
    localparam int CLK_PERIOD = 10;
    localparam int INIT_WAIT  = 30;
    localparam int T_RP       = 2;
    localparam int T_RC       = 5;
    localparam int T_MRD      = 2;
    localparam int INIT_REFS  = 2;
    localparam int RI         = 150;
    localparam int MAXO       = 8;
    // mode: BL code 3, interleaved, CL 2, single-write -> 0x22B
    localparam logic [11:0] MODEV = 12'h22B;
    // ext: temp code 2, array code 5 -> 0x015
    localparam logic [11:0] EXTV  = 12'h015;

    localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010, C_REF = 4'b0001, C_LMR = 4'b0000;

    logic clk = 0, rst = 1, bus_grant = 0;
    logic bus_req, ready, cs_n, ras_n, cas_n, we_n;
    logic [11:0] addr;
    logic [1:0]  ba;

    sdr_init_refresh #(
        .INIT_WAIT(INIT_WAIT), .T_RP(T_RP), .T_RC(T_RC), .T_MRD(T_MRD),
        .INIT_REFS(INIT_REFS), .REF_INTERVAL(RI), .MAX_OWED(MAXO),
        .MODE_VAL(MODEV), .EXT_MODE_VAL(EXTV)
    ) dut (
        .clk(clk), .rst(rst), .bus_grant(bus_grant), .bus_req(bus_req), .ready(ready),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0, bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor state (all sampled at negedge)
    int cyc = 0, r = -1, first_req = -1, nlog = 0;
    int log_s[8];
    logic [3:0] log_c[8];
    logic [11:0] log_a[8];
    logic [1:0] log_b[8];
    int rst_bad = 0, ready_fell = 0, gap_bad = 0, ref_nopre = 0, owed_noreq = 0;
    int nogrant_cmd = 0, pos_bad = 0, drain_bad = 0;
    int mpend = 0, gap = 0, burst_refs = 0, last_burst_refs = -1;
    int exp_pre_at = -1, exp_ref_at = -1;
    bit prev_ref_rdy = 0, in_burst = 0, have_last = 0, last_a10 = 0;
    logic [3:0] last_c = 4'b0111;

    always @(negedge clk) begin
        logic [3:0] c;
        int s, req;
        bit tk, sv;
        c = {cs_n, ras_n, cas_n, we_n};
        if (rst) begin
            if (c != C_NOP || ready || bus_req) rst_bad++;
        end else begin
            s = cyc;
            if (ready && r < 0) r = s;
            if (r >= 0 && !ready) ready_fell++;
            // owed-refresh model (R6, R9, R10)
            tk = (r >= 0 && s > r && ((s - r) % RI) == 0);
            sv = prev_ref_rdy;
            if (tk && !sv && mpend < MAXO) mpend++;
            else if (sv && !tk && mpend > 0) mpend--;
            prev_ref_rdy = ready && c == C_REF;
            if (mpend != 0 && !bus_req) owed_noreq++;
            if (r >= 0 && bus_req && first_req < 0) first_req = s;
            // grant response (R7)
            if (exp_pre_at == s) begin
                if (!(c == C_PRE && addr[10])) pos_bad++;
                exp_pre_at = -1;
                exp_ref_at = s + 1 + T_RP;
            end
            if (exp_ref_at == s) begin
                if (c != C_REF) pos_bad++;
                exp_ref_at = -1;
            end
            if (ready && c != C_NOP && !bus_grant) nogrant_cmd++;
            if (bus_req && bus_grant && !in_burst) begin
                in_burst = 1; exp_pre_at = s + 1; burst_refs = 0;
            end
            if (in_burst && c == C_REF) burst_refs++;
            if (in_burst && !bus_req) begin
                in_burst = 0;
                last_burst_refs = burst_refs;
                if (mpend != 0) drain_bad++;
            end
            // command log, spacing (R4), close-before-refresh (R8)
            if (c != C_NOP) begin
                if (nlog < 8) begin
                    log_s[nlog] = s; log_c[nlog] = c; log_a[nlog] = addr; log_b[nlog] = ba;
                    nlog++;
                end
                if (ready && c == C_REF && !(have_last && last_c == C_PRE && last_a10)) ref_nopre++;
                if (have_last) begin
                    req = (last_c == C_PRE) ? T_RP : (last_c == C_REF) ? T_RC : T_MRD;
                    if (!ready ? (gap != req) : (gap < req)) gap_bad++;
                end
                have_last = 1; last_c = c; last_a10 = addr[10]; gap = 0;
            end else begin
                gap++;
            end
            cyc++;
        end
    end

    // Waits for a request, holds the grant back, then serves one burst.
    task automatic serve(input int hold, input int exp_refs, input string tag);
        do begin @(posedge clk); #1; end while (!bus_req);
        repeat (hold) @(posedge clk);
        #1 bus_grant = 1;
        do begin @(posedge clk); #1; end while (bus_req);
        bus_grant = 0;
        @(negedge clk); #1;
        if (exp_refs >= 0)
            check(last_burst_refs == exp_refs, tag, last_burst_refs, exp_refs);
        else
            check(last_burst_refs >= 1, tag, last_burst_refs, 1);
    endtask

    initial begin
        int seed_v;
        seed_v = $urandom(32'd7331);
        repeat (5) @(posedge clk);
        #1 rst = 0;
        while (!ready) begin @(posedge clk); #1; end
        @(negedge clk); #1;

        check(rst_bad == 0, "R1 reset pins idle", rst_bad, 0);
        check(nlog >= 5, "R3 start-up command count", nlog, 5);
        check(log_s[0] == INIT_WAIT, "R2 idle cycles before first command", log_s[0], INIT_WAIT);
        check(log_c[0] == C_PRE && log_a[0][10], "R3 first is close-all", int'(log_c[0]), int'(C_PRE));
        check(log_c[1] == C_REF && log_c[2] == C_REF, "R3 two start-up refreshes",
              int'({log_c[1], log_c[2]}), int'({C_REF, C_REF}));
        check(log_c[3] == C_LMR && log_b[3] == 2'b00 && log_a[3] == MODEV, "R3 standard mode word",
              int'(log_a[3]), int'(MODEV));
        check(log_c[4] == C_LMR && log_b[4] == 2'b10 && log_a[4] == EXTV, "R3 extended mode word",
              int'({log_b[4], log_a[4]}), int'({2'b10, EXTV}));
        check(r == log_s[4] + T_MRD + 1, "R5 ready rise cycle", r, log_s[4] + T_MRD + 1);

        // R6/R7: single owed refresh, grant held back a few cycles
        serve(4, 1, "R7 single refresh burst");
        check(first_req == r + RI, "R6 first request cycle", first_req, r + RI);
        // R10: several owed refreshes served back-to-back
        serve(3 * RI + 20, 4, "R10 four owed refreshes");
        // R9: saturation after a long stall
        serve(10 * RI + 20, MAXO, "R9 saturated owed count");
        // random grant delays
        for (int i = 0; i < 12; i++) begin
            int d;
            d = $urandom_range(0, 2 * RI);
            serve(d, -1, "R10 random burst nonempty");
        end

        check(ready_fell == 0, "R5 ready never falls", ready_fell, 0);
        check(gap_bad == 0, "R4 command spacing", gap_bad, 0);
        check(ref_nopre == 0, "R8 close-all before refresh", ref_nopre, 0);
        check(owed_noreq == 0, "R6 request while owed", owed_noreq, 0);
        check(nogrant_cmd == 0, "R7 no command without grant", nogrant_cmd, 0);
        check(pos_bad == 0, "R7 close/refresh timing after grant", pos_bad, 0);
        check(drain_bad == 0, "R10 burst drains owed count", drain_bad, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        finished = 1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule